// File: doc/BRIEF.md
# Element-Width Indirect Load Address Sequencer

This block turns one vectorised indirect load command into a stream of per-element fetch requests. Each source address register holds the base address of a memory block as wide as the load operation. When the source elements are narrower than the load, several of them are packed into that block side by side, and the sequencer moves on to the next contiguous address register only once the block is used up. When an element is as wide as the load or wider, every element gets its own register and the fetch uses the load's own size.

A command gives the load width, the source element width code, the first address register number, an immediate offset and the vector length VL. The sequencer then issues one element per cycle under a valid/ready handshake. For each element it names the register to read. The register file answers on the same cycle with that register's base address. The sequencer combines that value with the immediate and the slot offset into a byte address, adds a fetch size, and flags the final element. Memory access, sign or zero extension and the destination write are done elsewhere.

Top module: `elemAddrSeq`

## Requirements
- R1: After reset, `cmdReady` is 1 and `reqValid` is 0.
- R2: A command is taken on a clock edge where `cmdValid` and `cmdReady` are both 1. With VL not zero, `reqValid` rises on the next cycle. `cmdReady` stays 0 until the last element has been accepted, and `cmdValid` is ignored during that time.
- R3: A command with VL = 0 produces no request, and `cmdReady` stays 1.
- R4: `cmdOpWidth` is log2 of the load width in bytes: 0 = 8, 1 = 16, 2 = 32, 3 = 64, 4 = 128 bits. Codes above 4 act as 4. The number of elements per block is the load width divided by the element width, and never less than 1.
- R5: Element i requests register `cmdBaseReg + floor(i / elementsPerBlock)`, modulo 2^REG_W.
- R6: The byte address of element i is `regBase + cmdImm + (i mod elementsPerBlock) * fetchBytes`, modulo 2^ADDR_W.
- R7: `reqSize` is log2 of the fetch size in bytes, which is the smaller of the element width and the load width.
- R8: `reqLast` is 1 only on element VL-1. After that element is accepted, `reqValid` falls and `cmdReady` rises on the next cycle.
- R9: While `reqValid` is 1 and `reqReady` is 0, the element does not advance, so `regIdx`, `reqSize` and `reqLast` hold their values.
- R10: `cmdElemCode` gives the element width: 1 = 8, 2 = 16, 3 = 32 bits, and 0 = the full XLEN width (64 bits by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Sequencer idle, command can be taken |
| cmdOpWidth | input | 3 | Load width code, log2 of bytes |
| cmdElemCode | input | 2 | Source element width code |
| cmdBaseReg | input | REG_W | First address register number |
| cmdImm | input | ADDR_W | Immediate byte offset |
| cmdVl | input | VL_W | Number of elements |
| regIdx | output | REG_W | Address register to read for the current element |
| regBase | input | ADDR_W | Base address held in `regIdx`, returned on the same cycle |
| reqValid | output | 1 | Element request present |
| reqReady | input | 1 | Element request taken |
| reqAddr | output | ADDR_W | Byte address of the element |
| reqSize | output | 3 | Fetch size, log2 of bytes |
| reqLast | output | 1 | Current element is the final one |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 7-bit register numbers, an 8-bit VL and a 64-bit XLEN. With a 7-bit register number, a base near 127 makes the register index wrap within a short sequence. With a 64-bit XLEN, width code 0 gives eight-byte elements, so that code can be set both wider and narrower than the load. Loads of 8 to 128 bits with 8-bit elements give from 1 to 16 elements per block. Random VL values up to 40 therefore cross several block boundaries, and the bench also drives directed cases for VL of 0 and 1.

// File: rtl/elemSeqPkg.sv
package elemSeqPkg;

  typedef struct packed {
    logic load;     // capture a new command
    logic advance;  // step to the next element
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  localparam logic [2:0] MAX_OP_LOG = 3'd4;

  // load width code, clamped to 128 bits
  function automatic logic [2:0] opLogOf(input logic [2:0] code);
    return (code > MAX_OP_LOG) ? MAX_OP_LOG : code;
  endfunction

  // element width code to log2 bytes; code 0 selects XLEN
  function automatic logic [2:0] elemLogOf(input logic [1:0] code,
                                           input logic [2:0] xlenLog);
    logic [2:0] r;
    case (code)
      2'd1:    r = 3'd0;
      2'd2:    r = 3'd1;
      2'd3:    r = 3'd2;
      default: r = xlenLog;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/elemSeqCtrl.sv
module elemSeqCtrl
  import elemSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdVlZero,
  input  logic       reqReady,
  input  logic       isLast,
  output logic       cmdReady,
  output logic       reqValid,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (cmdValid) begin
          strobe.load = 1'b1;
          if (!cmdVlZero) stateNext = SEQ_RUN;
        end
      end
      default: begin
        if (reqReady) begin
          if (isLast) stateNext = SEQ_IDLE;
          else        strobe.advance = 1'b1;
        end
      end
    endcase
  end

  assign cmdReady = (state == SEQ_IDLE);
  assign reqValid = (state == SEQ_RUN);

endmodule

// File: rtl/elemSeqDatapath.sv
module elemSeqDatapath
  import elemSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 7,
  parameter int VL_W   = 8,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        cmdOpWidth,
  input  logic [1:0]        cmdElemCode,
  input  logic [REG_W-1:0]  cmdBaseReg,
  input  logic [ADDR_W-1:0] cmdImm,
  input  logic [VL_W-1:0]   cmdVl,
  input  logic [ADDR_W-1:0] regBase,
  output logic [REG_W-1:0]  regIdx,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [2:0]        reqSize,
  output logic              isLast
);

  localparam logic [2:0] XLEN_LOG = 3'($clog2(XLEN / 8));

  logic [2:0]        sizeLogQ, epbLogQ;
  logic [REG_W-1:0]  baseRegQ;
  logic [ADDR_W-1:0] immQ;
  logic [VL_W-1:0]   lastIdxQ, idxQ;

  logic [2:0] opLog, elemLog;
  assign opLog   = opLogOf(cmdOpWidth);
  assign elemLog = elemLogOf(cmdElemCode, XLEN_LOG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeLogQ <= '0;
      epbLogQ  <= '0;
      baseRegQ <= '0;
      immQ     <= '0;
      lastIdxQ <= '0;
      idxQ     <= '0;
    end else if (strobe.load) begin
      // fetch is the narrower of element and load; at least one per block
      sizeLogQ <= (opLog < elemLog) ? opLog : elemLog;
      epbLogQ  <= (opLog > elemLog) ? (opLog - elemLog) : 3'd0;
      baseRegQ <= cmdBaseReg;
      immQ     <= cmdImm;
      lastIdxQ <= cmdVl - VL_W'(1);
      idxQ     <= '0;
    end else if (strobe.advance) begin
      idxQ <= idxQ + VL_W'(1);
    end
  end

  logic [VL_W-1:0]   blockIdx, slotIdx;
  logic [ADDR_W-1:0] slotOffset;

  always_comb begin
    blockIdx   = idxQ >> epbLogQ;
    slotIdx    = idxQ - (blockIdx << epbLogQ);
    slotOffset = ADDR_W'(slotIdx) << sizeLogQ;
  end

  assign regIdx  = baseRegQ + REG_W'(blockIdx);
  assign reqAddr = regBase + immQ + slotOffset;
  assign reqSize = sizeLogQ;
  assign isLast  = (idxQ == lastIdxQ);

endmodule

// File: rtl/elemAddrSeq.sv
module elemAddrSeq
  import elemSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 7,
  parameter int VL_W   = 8,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOpWidth,
  input  logic [1:0]        cmdElemCode,
  input  logic [REG_W-1:0]  cmdBaseReg,
  input  logic [ADDR_W-1:0] cmdImm,
  input  logic [VL_W-1:0]   cmdVl,
  output logic [REG_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] regBase,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [2:0]        reqSize,
  output logic              reqLast
);

  seqStrobe_t strobe;
  logic       isLast;
  logic       cmdVlZero;

  assign cmdVlZero = (cmdVl == '0);

  elemSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdVlZero (cmdVlZero),
    .reqReady  (reqReady),
    .isLast    (isLast),
    .cmdReady  (cmdReady),
    .reqValid  (reqValid),
    .strobe    (strobe)
  );

  elemSeqDatapath #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .VL_W   (VL_W),
    .XLEN   (XLEN)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdOpWidth  (cmdOpWidth),
    .cmdElemCode (cmdElemCode),
    .cmdBaseReg  (cmdBaseReg),
    .cmdImm      (cmdImm),
    .cmdVl       (cmdVl),
    .regBase     (regBase),
    .regIdx      (regIdx),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .isLast      (isLast)
  );

  assign reqLast = reqValid & isLast;

endmodule

// File: rtl/elemAddrSeqChecker.sv
module elemAddrSeqChecker #(
  parameter int REG_W = 7,
  parameter int VL_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [VL_W-1:0]  cmdVl,
  input logic [REG_W-1:0] regIdx,
  input logic             reqValid,
  input logic             reqReady,
  input logic [2:0]       reqSize,
  input logic             reqLast
);

  // R2: idle and issuing never overlap
  a_r2_idle_xor_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !cmdReady);

  // R2: a command with nonzero VL starts issuing
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdVl != '0) |=> reqValid);

  // R3: zero VL issues nothing
  a_r3_zero_vl: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdVl == '0) |=> (cmdReady && !reqValid));

  // R5: register index stays or steps by one between elements
  a_r5_reg_step: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqLast) |=>
      (reqValid && (regIdx == $past(regIdx) || regIdx == $past(regIdx) + REG_W'(1))));

  // R7: fetch size never exceeds 128 bits
  a_r7_size_range: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqSize <= 3'd4));

  // R8: accepting the last element ends the sequence
  a_r8_last_done: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLast) |=> (!reqValid && cmdReady));

  // R9: stall holds the request
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=>
      (reqValid && $stable(regIdx) && $stable(reqSize) && $stable(reqLast)));

endmodule

bind elemAddrSeq elemAddrSeqChecker #(.REG_W(REG_W), .VL_W(VL_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdVl    (cmdVl),
  .regIdx   (regIdx),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqSize  (reqSize),
  .reqLast  (reqLast)
);

// File: tb/sim_elemAddrSeq.sv
`timescale 1ns/1ps
module sim_elemAddrSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOpWidth = '0;
  logic [1:0]  cmdElemCode = '0;
  logic [6:0]  cmdBaseReg = '0;
  logic [31:0] cmdImm = '0;
  logic [7:0]  cmdVl = '0;
  logic [6:0]  regIdx;
  logic [31:0] regBase;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [31:0] reqAddr;
  logic [2:0]  reqSize;
  logic        reqLast;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  // register file model: each register holds a distinct base address
  function automatic logic [31:0] baseOf(input logic [6:0] r);
    return 32'h4000_0000 + (32'(r) << 12);
  endfunction

  assign regBase = baseOf(regIdx);

  elemAddrSeq u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOpWidth(cmdOpWidth), .cmdElemCode(cmdElemCode), .cmdBaseReg(cmdBaseReg),
    .cmdImm(cmdImm), .cmdVl(cmdVl), .regIdx(regIdx), .regBase(regBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqLast(reqLast)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected-value model
  function automatic int opL(input int c);
    return (c > 4) ? 4 : c;
  endfunction
  function automatic int elL(input int c);
    return (c == 0) ? 3 : c - 1;   // R10: code 0 is 64-bit XLEN
  endfunction
  function automatic int epbL(input int op, input int el);
    return (opL(op) > elL(el)) ? opL(op) - elL(el) : 0;
  endfunction
  function automatic int szL(input int op, input int el);
    return (opL(op) < elL(el)) ? opL(op) : elL(el);
  endfunction

  task automatic runCmd(input int op, input int el, input int base,
                        input logic [31:0] imm, input int vl, input bit noise);
    int e = epbL(op, el);
    int s = szL(op, el);
    int i = 0;
    @(negedge clk);
    chk(cmdReady == 1'b1, "R2 ready before command", longint'(cmdReady), 1);
    cmdValid    = 1'b1;
    cmdOpWidth  = 3'(op);
    cmdElemCode = 2'(el);
    cmdBaseReg  = 7'(base);
    cmdImm      = imm;
    cmdVl       = 8'(vl);
    @(negedge clk);
    if (noise) begin
      // R2: a command offered while busy must be ignored
      cmdOpWidth = 3'd0; cmdElemCode = 2'd1; cmdBaseReg = 7'd3;
      cmdImm = 32'hdead; cmdVl = 8'd2;
    end else begin
      cmdValid = 1'b0;
    end
    if (vl == 0) begin
      chk(!reqValid && cmdReady, "R3 zero VL idle", longint'({reqValid, cmdReady}), 1);
      cmdValid = 1'b0;
      return;
    end
    while (i < vl) begin
      logic [6:0]  expReg  = 7'(base + (i >> e));
      logic [31:0] expAddr = baseOf(expReg) + imm + 32'((i & ((1 << e) - 1)) << s);
      bit rdy;
      chk(reqValid == 1'b1, "R2 request valid", longint'(reqValid), 1);
      chk(cmdReady == 1'b0, "R2 busy not ready", longint'(cmdReady), 0);
      chk(regIdx == expReg, "R5 register index", longint'(regIdx), longint'(expReg));
      chk(reqAddr == expAddr, "R6 byte address", longint'(reqAddr), longint'(expAddr));
      chk(int'(reqSize) == s, "R7 fetch size", longint'(reqSize), longint'(s));
      chk(reqLast == (i == vl - 1), "R8 last flag", longint'(reqLast), longint'(i == vl - 1));
      rdy = ($urandom % 4) != 0;
      reqReady = rdy;
      @(negedge clk);
      if (rdy) i++;
    end
    cmdValid = 1'b0;
    reqReady = 1'b0;
    chk(!reqValid && cmdReady, "R8 idle after last", longint'({reqValid, cmdReady}), 1);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(cmdReady == 1'b1, "R1 reset cmdReady", longint'(cmdReady), 1);
    chk(reqValid == 1'b0, "R1 reset reqValid", longint'(reqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady == 1'b1 && reqValid == 1'b0, "R1 idle after reset",
        longint'({cmdReady, reqValid}), 2);

    // R4 R5: 64-bit load, 16-bit elements, VL=7 -> four in first register, three in next
    runCmd(3, 2, 5, 32'h10, 7, 1'b0);
    // R4 R7 R10: 64-bit elements (code 0) on an 8-bit load -> one per block, size 0
    runCmd(0, 0, 9, 32'h4, 5, 1'b0);
    // R10: XLEN elements in a 128-bit load -> two per block, size 3
    runCmd(4, 0, 20, 32'h0, 6, 1'b0);
    // R4: code above 4 acts as 128 bits; 8-bit elements -> 16 per block
    runCmd(7, 1, 30, 32'h100, 20, 1'b0);
    // R5: register index wraps past 127
    runCmd(0, 1, 126, 32'h8, 4, 1'b0);
    // R3: VL of zero
    runCmd(3, 1, 1, 32'h0, 0, 1'b0);
    // R8: VL of one
    runCmd(2, 3, 40, 32'hfffffffc, 1, 1'b0);
    // R2: command input held busy during a run is ignored
    runCmd(2, 1, 50, 32'h20, 9, 1'b1);

    for (int k = 0; k < 60; k++) begin
      runCmd(int'($urandom % 6), int'($urandom % 4), int'($urandom % 128),
             $urandom, int'($urandom % 41), 1'(($urandom % 5) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule